// File: doc/BRIEF.md
# Table Entry Read Responder

This block answers table-read requests that arrive as three-dword data objects on a mailbox. It holds a device attribute table in a small read-only memory. The table is a list of variable-length entries, and entry 0 is the table header. A request names one entry by its handle. The block replies with a three-dword object header, then the dwords of that entry, and puts the handle of the following entry in the reply. A host reads the whole table by starting at handle 0 and following the returned handles until it sees 0xFFFF.

The memory holds no table of entry offsets. To locate an entry, the block walks the table from the first entry after the header. At each step it takes the entry's size from the byte-length field in that entry's first dword. Requests arrive as a dword stream and replies leave as a dword stream, each with valid/ready handshaking. A request that cannot be served produces a one-cycle error pulse and no reply. The table contents come from a package function that the parameters drive.

Top module: `tbl_entry_responder`

## Requirements
- R1: A request is exactly three dwords, each accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the acceptance of the third dword until the reply's last dword is accepted, and it is high again on the cycle after that.
- R2: Reply dword 0 holds the vendor ID (`VENDOR_ID`, default 0x1E98) in bits 15:0 and the object type `OBJ_TYPE` (default 2) in bits 23:16, with bits 31:24 zero.
- R3: Reply dword 1 holds, in bits 17:0, three plus the number of entry dwords returned. Its bits 31:18 are zero.
- R4: Reply dword 2 holds request code 0 in bits 7:0 and table type 0 in bits 15:8. Bits 31:16 hold the next handle: requested handle plus one, or 0xFFFF when the requested entry is the last one (handle `NUM_ENTRIES`-1).
- R5: Handle 0 returns the three header dwords: total table length in bytes; revision in bits 7:0 with the stored checksum byte in bits 15:8; and the sequence number.
- R6: Handles are entry indices. Handle k≥1 selects the k-th entry after the header, located by summing the sizes (first-dword bits 31:16, in bytes, divided by 4) of entries 1..k-1 starting at word 3. The entry's memory words are returned in order. In the default table, entry k has 2+(7k mod 34) dwords, and its first dword is {byte length, 8'h00, k mod 6}. Word o>0 is {k, o, 0xA5C3 xor its address}.
- R7: A reply never exceeds `MAX_RESP_DW` (default 32) dwords in total. An entry longer than `MAX_RESP_DW`-3 dwords is cut to its first `MAX_RESP_DW`-3 dwords, and dword 1 reports the cut length.
- R8: `resp_last` is high only on the final reply dword. While `resp_valid` is high and `resp_ready` is low, `resp_data` and `resp_last` hold their values.
- R9: A request gets a single-cycle `err` pulse and no reply dwords if any of these hold: the request code is nonzero; the table type is nonzero; the handle is `NUM_ENTRIES` or more; request dword 0 does not carry the vendor ID and object type; or request dword 1 bits 17:0 are not 3.
- R10: After synchronous reset, `resp_valid` and `err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request dword valid |
| req_ready | output | 1 | Request dword accepted when high with `req_valid` |
| req_data | input | 32 | Request dword |
| resp_valid | output | 1 | Reply dword valid |
| resp_ready | input | 1 | Consumer takes the reply dword |
| resp_data | output | 32 | Reply dword |
| resp_last | output | 1 | Final dword of the reply |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions assume the consumer eventually raises `resp_ready`. They also assume every table entry declares a nonzero length, and the bench's table generator only makes entries of two dwords or more. The error-pulse property relies on a new request needing three accepted dwords, so two rejections can never fall on adjacent cycles; the bench only sends whole three-dword requests. The bench drives `resp_ready` with continuous, every-other-cycle and one-in-three patterns, so the hold property is exercised under real backpressure.

// File: rtl/tblrsp_pkg.sv
package tblrsp_pkg;

  localparam int unsigned HDR_DW = 3;
  localparam logic [15:0] END_HANDLE = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK_RD,
    ST_WALK_CHK,
    ST_FETCH,
    ST_PUT,
    ST_HOLD
  } eng_state_e;

  typedef struct packed {
    logic        hdr_ok;
    logic [7:0]  code;
    logic [7:0]  ttype;
    logic [15:0] handle;
  } tbl_cmd_t;

  // dword count of entry k (k >= 1)
  function automatic int unsigned entry_dw(int unsigned k, int unsigned span);
    return 2 + ((7 * k) % span);
  endfunction

  function automatic int unsigned table_dw(int unsigned n, int unsigned span);
    int unsigned t;
    t = HDR_DW;
    for (int unsigned k = 1; k < n; k++) t += entry_dw(k, span);
    return t;
  endfunction

  function automatic logic [31:0] rom_word(int unsigned a, int unsigned n, int unsigned span,
                                           logic [7:0] rev, logic [7:0] chk, logic [31:0] seq);
    int unsigned s;
    int unsigned len;
    logic [31:0] w;
    w = '0;
    if (a == 0) w = 32'(4 * table_dw(n, span));
    else if (a == 1) w = {16'h0000, chk, rev};
    else if (a == 2) w = seq;
    else begin
      s = HDR_DW;
      for (int unsigned k = 1; k < n; k++) begin
        len = entry_dw(k, span);
        if (a >= s && a < s + len) begin
          if (a == s) w = {16'(4 * len), 8'h00, 8'(k % 6)};
          else        w = {8'(k), 8'(a - s), 16'hA5C3 ^ 16'(a)};
        end
        s += len;
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/tblrsp_rom.sv
module tblrsp_rom
  import tblrsp_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 6,
  parameter int unsigned LEN_SPAN    = 34,
  parameter logic [7:0]  TBL_REV     = 8'h01,
  parameter logic [7:0]  TBL_CHK     = 8'h00,
  parameter logic [31:0] TBL_SEQ     = 32'd7,
  parameter int unsigned DEPTH       = table_dw(NUM_ENTRIES, LEN_SPAN),
  parameter int unsigned AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);

  logic [31:0] mem [DEPTH];

  initial begin
    for (int unsigned i = 0; i < DEPTH; i++)
      mem[i] = rom_word(i, NUM_ENTRIES, LEN_SPAN, TBL_REV, TBL_CHK, TBL_SEQ);
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/tblrsp_req_rx.sv
module tblrsp_req_rx
  import tblrsp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1E98,
  parameter logic [7:0]  OBJ_TYPE  = 8'd2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_data,
  output logic        req_ready,
  input  logic        eng_idle,
  output logic        cmd_valid,
  output tbl_cmd_t    cmd
);

  logic [1:0] wcnt;
  logic       ok_w0;
  logic       ok_w1;
  logic       take;

  assign req_ready = eng_idle && !cmd_valid;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt      <= '0;
      ok_w0     <= 1'b0;
      ok_w1     <= 1'b0;
      cmd_valid <= 1'b0;
      cmd       <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (take) begin
        case (wcnt)
          2'd0: begin
            ok_w0 <= (req_data[15:0] == VENDOR_ID) && (req_data[23:16] == OBJ_TYPE);
            wcnt  <= 2'd1;
          end
          2'd1: begin
            ok_w1 <= (req_data[17:0] == 18'd3);
            wcnt  <= 2'd2;
          end
          default: begin
            cmd_valid  <= 1'b1;
            cmd.hdr_ok <= ok_w0 && ok_w1;
            cmd.code   <= req_data[7:0];
            cmd.ttype  <= req_data[15:8];
            cmd.handle <= req_data[31:16];
            wcnt       <= 2'd0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/tblrsp_engine.sv
module tblrsp_engine
  import tblrsp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1E98,
  parameter logic [7:0]  OBJ_TYPE    = 8'd2,
  parameter int unsigned NUM_ENTRIES = 6,
  parameter int unsigned MAX_RESP_DW = 32,
  parameter int unsigned AW          = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  tbl_cmd_t      cmd,
  output logic          eng_idle,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [31:0]   resp_data,
  output logic          resp_last,
  output logic          err
);

  localparam int unsigned MAX_ENTRY_DW = MAX_RESP_DW - HDR_DW;
  localparam int unsigned CW           = $clog2(MAX_RESP_DW + 1);

  eng_state_e      state;
  logic [15:0]     handle_q;
  logic [15:0]     idx;
  logic [AW-1:0]   cur;
  logic [AW-1:0]   start;
  logic [CW-1:0]   ent_dw;
  logic [CW-1:0]   widx;
  logic [CW-1:0]   tot_dw;
  logic [13:0]     rom_dw;
  logic [15:0]     nxt_handle;
  logic [31:0]     hdr_word;
  logic [AW-1:0]   ent_addr;
  logic            bad_cmd;
  logic [CW-1:0]   sent_cnt;

  assign eng_idle   = (state == ST_IDLE);
  assign rom_dw     = rd_data[31:18];
  assign tot_dw     = CW'(HDR_DW) + ent_dw;
  assign nxt_handle = (handle_q == 16'(NUM_ENTRIES - 1)) ? END_HANDLE : handle_q + 16'd1;
  assign bad_cmd    = !cmd.hdr_ok || (cmd.code != 8'h00) || (cmd.ttype != 8'h00) ||
                      (cmd.handle >= 16'(NUM_ENTRIES));
  assign ent_addr   = (widx < CW'(HDR_DW)) ? start : start + AW'(widx) - AW'(HDR_DW);
  assign rd_addr    = (state == ST_WALK_RD) ? cur : ent_addr;

  always_comb begin
    case (widx)
      CW'(0):  hdr_word = {8'h00, OBJ_TYPE, VENDOR_ID};
      CW'(1):  hdr_word = {14'h0000, 18'(HDR_DW + ent_dw)};
      default: hdr_word = {nxt_handle, 8'h00, 8'h00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      handle_q   <= '0;
      idx        <= '0;
      cur        <= '0;
      start      <= '0;
      ent_dw     <= '0;
      widx       <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_last  <= 1'b0;
      err        <= 1'b0;
    end else begin
      err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (bad_cmd) begin
              err <= 1'b1;
            end else begin
              handle_q <= cmd.handle;
              widx     <= '0;
              if (cmd.handle == 16'd0) begin
                start  <= '0;
                ent_dw <= CW'(HDR_DW);
                state  <= ST_FETCH;
              end else begin
                cur   <= AW'(HDR_DW);
                idx   <= 16'd1;
                state <= ST_WALK_RD;
              end
            end
          end
        end
        ST_WALK_RD: state <= ST_WALK_CHK;
        ST_WALK_CHK: begin
          if (idx == handle_q) begin
            start  <= cur;
            ent_dw <= (rom_dw > 14'(MAX_ENTRY_DW)) ? CW'(MAX_ENTRY_DW) : CW'(rom_dw);
            state  <= ST_FETCH;
          end else begin
            cur   <= cur + AW'(rom_dw);
            idx   <= idx + 16'd1;
            state <= ST_WALK_RD;
          end
        end
        ST_FETCH: state <= ST_PUT;
        ST_PUT: begin
          resp_data  <= (widx < CW'(HDR_DW)) ? hdr_word : rd_data;
          resp_last  <= (widx == tot_dw - CW'(1));
          resp_valid <= 1'b1;
          state      <= ST_HOLD;
        end
        ST_HOLD: begin
          if (resp_ready) begin
            resp_valid <= 1'b0;
            resp_last  <= 1'b0;
            if (resp_last) begin
              state <= ST_IDLE;
            end else begin
              widx  <= widx + CW'(1);
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // words handed over in the reply under way
  always_ff @(posedge clk) begin
    if (rst) sent_cnt <= '0;
    else if (resp_valid && resp_ready) sent_cnt <= resp_last ? '0 : sent_cnt + CW'(1);
  end

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data) && $stable(resp_last)); // R8
  AST_RESP_CAP: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_ready |-> 32'(sent_cnt) < MAX_RESP_DW); // R7
  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
    resp_valid && sent_cnt == '0 |-> resp_data == {8'h00, OBJ_TYPE, VENDOR_ID}); // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> !resp_valid); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err |=> !err); // R9
  AST_ENTRY_LEN: assert property (@(posedge clk) disable iff (rst)
    state == ST_WALK_CHK |-> rom_dw != 14'd0); // R6

endmodule

// File: rtl/tbl_entry_responder.sv
module tbl_entry_responder
  import tblrsp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1E98,
  parameter logic [7:0]  OBJ_TYPE    = 8'd2,
  parameter int unsigned NUM_ENTRIES = 6,
  parameter int unsigned LEN_SPAN    = 34,
  parameter int unsigned MAX_RESP_DW = 32,
  parameter logic [7:0]  TBL_REV     = 8'h01,
  parameter logic [7:0]  TBL_CHK     = 8'h00,
  parameter logic [31:0] TBL_SEQ     = 32'd7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_data,
  output logic        resp_valid,
  input  logic        resp_ready,
  output logic [31:0] resp_data,
  output logic        resp_last,
  output logic        err
);

  localparam int unsigned DEPTH = table_dw(NUM_ENTRIES, LEN_SPAN);
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          eng_idle;
  logic          cmd_valid;
  tbl_cmd_t      cmd;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;

  tblrsp_req_rx #(.VENDOR_ID(VENDOR_ID), .OBJ_TYPE(OBJ_TYPE)) u_rx (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data),
    .req_ready(req_ready), .eng_idle(eng_idle), .cmd_valid(cmd_valid), .cmd(cmd)
  );

  tblrsp_rom #(
    .NUM_ENTRIES(NUM_ENTRIES), .LEN_SPAN(LEN_SPAN), .TBL_REV(TBL_REV),
    .TBL_CHK(TBL_CHK), .TBL_SEQ(TBL_SEQ), .DEPTH(DEPTH), .AW(AW)
  ) u_rom (
    .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  tblrsp_engine #(
    .VENDOR_ID(VENDOR_ID), .OBJ_TYPE(OBJ_TYPE), .NUM_ENTRIES(NUM_ENTRIES),
    .MAX_RESP_DW(MAX_RESP_DW), .AW(AW)
  ) u_eng (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .eng_idle(eng_idle),
    .rd_addr(rd_addr), .rd_data(rd_data), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data), .resp_last(resp_last), .err(err)
  );

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !req_ready); // R1

endmodule

// File: tb/tb_tbl_entry_responder.sv
module tb_tbl_entry_responder;

  localparam int unsigned N = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_data = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [31:0] resp_data;
  logic        resp_last;
  logic        err;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got [0:63];

  always #10 clk = ~clk;

  tbl_entry_responder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .resp_last(resp_last), .err(err)
  );

  function automatic int unsigned b_len(int unsigned k);
    return 2 + ((7 * k) % 34);
  endfunction

  function automatic int unsigned b_start(int unsigned k);
    int unsigned s = 3;
    for (int unsigned j = 1; j < k; j++) s += b_len(j);
    return s;
  endfunction

  function automatic logic [31:0] b_word(int unsigned k, int unsigned o);
    int unsigned a = b_start(k) + o;
    if (k == 0) begin
      if (o == 0) return 32'(4 * b_start(N));
      if (o == 1) return 32'h0000_0001;
      return 32'd7;
    end
    if (o == 0) return {16'(4 * b_len(k)), 8'h00, 8'(k % 6)};
    return {8'(k), 8'(o), 16'hA5C3 ^ 16'(a)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    req_data  = w;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    push(w0);
    push(w1);
    push(w2);
  endtask

  task automatic collect(input int bp, input int limit, output int n, output bit saw_err);
    int cyc = 0;
    bit done = 0;
    bit holding = 0;
    logic [31:0] held = '0;
    logic held_last = 1'b0;
    n = 0;
    saw_err = 0;
    while (!done && cyc < limit) begin
      @(negedge clk);
      cyc++;
      if (err) saw_err = 1;
      if (holding && resp_valid)
        chk(resp_data == held && resp_last == held_last, "R8 hold", resp_data, held);
      resp_ready = (bp == 0) ? 1'b1 : (bp == 1) ? (cyc % 2 == 0) : (cyc % 3 == 2);
      if (resp_valid && resp_ready) begin
        if (n == 0) chk(req_ready == 1'b0, "R1 busy", 32'(req_ready), 32'd0);
        if (n < 64) got[n] = resp_data;
        n++;
        if (resp_last) done = 1;
      end
      holding   = resp_valid && !resp_ready;
      held      = resp_data;
      held_last = resp_last;
    end
    @(negedge clk);
    resp_ready = 1'b0;
    if (err) saw_err = 1;
  endtask

  function automatic logic [31:0] w0_ok();
    return {8'h00, 8'd2, 16'h1E98};
  endfunction

  task automatic read_entry(input int unsigned h, input int bp, output logic [15:0] nxt);
    int n;
    bit e;
    int unsigned body;
    logic [15:0] exp_nxt;
    body    = (h == 0) ? 3 : ((b_len(h) > 29) ? 29 : b_len(h));
    exp_nxt = (h == N - 1) ? 16'hFFFF : 16'(h + 1);
    send(w0_ok(), 32'd3, {16'(h), 16'h0000});
    collect(bp, 600, n, e);
    chk(n == int'(3 + body), (body == 29) ? "R7 count" : "R8 count", 32'(n), 32'(3 + body));
    chk(!e, "R9 no err", 32'(e), 32'd0);
    chk(req_ready == 1'b1, "R1 ready again", 32'(req_ready), 32'd1);
    if (n == int'(3 + body)) begin
      chk(got[0] == w0_ok(), "R2 dword0", got[0], w0_ok());
      chk(got[1] == 32'(3 + body), "R3 length", got[1], 32'(3 + body));
      chk(got[2] == {exp_nxt, 16'h0000}, "R4 next", got[2], {exp_nxt, 16'h0000});
      for (int unsigned i = 0; i < body; i++)
        chk(got[3 + i] == b_word(h, i), (h == 0) ? "R5 header" : "R6 entry", got[3 + i], b_word(h, i));
    end
    nxt = got[2][31:16];
  endtask

  task automatic bad_req(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                         input string rq);
    int n;
    bit e;
    send(w0, w1, w2);
    collect(0, 20, n, e);
    chk(e, rq, 32'(e), 32'd1);
    chk(n == 0, rq, 32'(n), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] h;
    int walk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(resp_valid == 1'b0, "R10 valid", 32'(resp_valid), 32'd0);
    chk(err == 1'b0, "R10 err", 32'(err), 32'd0);
    chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 32'd1);

    for (int bp = 0; bp < 3; bp++)
      for (int unsigned k = 0; k < N; k++) read_entry(k, bp, h);

    // R4 chain from handle 0 to the end marker
    h = 16'd0;
    walk = 0;
    while (h != 16'hFFFF && walk < 10) begin
      read_entry(int'(h), 1, h);
      walk++;
    end
    chk(walk == int'(N), "R4 chain length", 32'(walk), 32'(N));

    bad_req(w0_ok(), 32'd3, {16'(N), 16'h0000}, "R9 handle past end");
    bad_req(w0_ok(), 32'd3, {16'hFFFF, 16'h0000}, "R9 handle FFFF");
    bad_req(w0_ok(), 32'd3, {16'd1, 8'h00, 8'h01}, "R9 code");
    bad_req(w0_ok(), 32'd3, {16'd1, 8'h01, 8'h00}, "R9 table type");
    bad_req({8'h00, 8'd2, 16'h1234}, 32'd3, {16'd1, 16'h0000}, "R9 vendor");
    bad_req({8'h00, 8'd1, 16'h1E98}, 32'd3, {16'd1, 16'h0000}, "R9 object type");
    bad_req(w0_ok(), 32'd4, {16'd1, 16'h0000}, "R9 length");

    read_entry(2, 2, h);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule